// File: doc/BRIEF.md
# Flyback Controller Fault Supervisor

This block decides whether an LED flyback controller may switch. It watches digitized supply comparators, a line-presence flag, thermal shutdown and three short-circuit indications, and from them runs a six-state supervisor. The states are Reset, Stop, Run, Discharge, Timer and Latch. Only Run lets the gate driver pulse. The block also qualifies its two timed faults itself. The first is an auxiliary-winding short: the zero-crossing input stays below its short level for a programmable number of cycles. The second is a current-sense pin short: the sense signal is still under its low threshold once a line-dependent blanking time of the on-time has passed.

There are two fault classes. A winding or output-diode short is taken only inside the leading-edge blanking window. It cuts the run enable in the same cycle and, like the auxiliary short, forms the severe class. A build parameter sends the severe class either to a recovery timer (auto-recovery) or to a latch (latched build). Supply over-voltage always uses the recovery timer. Loss of line, over-temperature and a current-sense short form the mild class and wait in Discharge for the supply to collapse. Every entry into Run opens a soft-start window. All time constants are cycle-count parameters.

Top module: `flyback_fault_supervisor`

## Requirements
- R1: While reset is asserted and just after it is released, state_o is 0 (Reset), startup_low_o is 1, and run_en_o and softstart_o are 0. The state codes are Reset=0, Stop=1, Run=2, Discharge=3, Timer=4 and Latch=5.
- R2: From Reset, vcc_on_i high moves the state to Stop at the next edge. In Stop, Run or Discharge, vcc_off_ok_i low moves the state to Reset at the next edge.
- R3: Stop moves to Run when line_ok_i is 1, tsd_i is 0 and vcc_ovp_i is 0. softstart_o is 1 for exactly SS_CYCLES cycles of Run, starting with the first cycle after each entry into Run.
- R4: In Run, line_ok_i low, tsd_i high or a qualified current-sense short moves the state to Discharge. Discharge returns to Reset when line_ok_i is 1 or vcc_off_ok_i is 0.
- R5: In Run, vcc_ovp_i high moves the state to Timer. Timer lasts at least REC_CYCLES+1 cycles. It then moves to Stop in the first cycle in which the timer has expired and vcc_on_i is 1.
- R6: In Run, zcd_short_i high for AUX_CYCLES consecutive cycles raises a severe fault. Any cycle with zcd_short_i low, or any cycle outside Run, clears the count.
- R7: wod_i counts only while leb_i is 1. In Run, wod_i and leb_i both high force run_en_o to 0 in the same cycle and raise a severe fault. wod_i high with leb_i low has no effect.
- R8: A current-sense short is qualified when drv_on_i has been high for BLANK_LO_CYCLES cycles (line_high_i=0) or BLANK_HI_CYCLES cycles (line_high_i=1) and cs_low_i is still 1 in the following cycle. A drv_on_i low cycle clears the count.
- R9: With LATCHED=0 a severe fault in Run moves the state to Timer. With LATCHED=1 it moves the state to Latch, which is left only for Reset when vcc_rst_ok_i is 0.
- R10: vcc_rst_ok_i low sends every state to Reset at the next edge. In Run the priority is: supply below off level first, then severe fault, then over-voltage, then the mild class.
- R11: run_en_o is 1 only in Run, and startup_low_o is 1 only in Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply at or above start level |
| vcc_off_ok_i | input | 1 | Supply above minimum operating level |
| vcc_rst_ok_i | input | 1 | Supply above logic reset level |
| vcc_ovp_i | input | 1 | Supply over-voltage |
| line_ok_i | input | 1 | Line present (brown-out not active) |
| tsd_i | input | 1 | Thermal shutdown |
| cs_low_i | input | 1 | Current sense below its low threshold |
| wod_i | input | 1 | Winding/diode short comparator |
| leb_i | input | 1 | Main leading-edge blanking window active |
| drv_on_i | input | 1 | Gate drive in on-time |
| line_high_i | input | 1 | High line: selects the short sense blanking |
| zcd_short_i | input | 1 | Zero-crossing input below short level |
| run_en_o | output | 1 | Switching allowed |
| startup_low_o | output | 1 | Low startup current mode |
| softstart_o | output | 1 | Soft-start window active |
| state_o | output | 3 | Supervisor state code |

## Verification
A severe fault and a mild fault or over-voltage can arrive in the same Run cycle. Supply loss can also coincide with over-voltage. Directed steps raise wod_i with leb_i, vcc_ovp_i, tsd_i and line_ok_i low together. The following state must be Timer or Latch (depending on the build) and never Discharge. Another step drops vcc_off_ok_i together with over-voltage and must reach Reset. Random stimulus keeps producing such overlaps, and both builds are compared each cycle with a bench reference model.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_STOP  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DISCH = 3'd3,
        ST_TIMER = 3'd4,
        ST_LATCH = 3'd5
    } fsup_state_e;
endpackage

// File: rtl/fsup_qual_timer.sv
module fsup_qual_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cond_i,
    output logic hit_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (en_i && cond_i) begin
            cnt_d = (cnt_q == TOP) ? cnt_q : cnt_q + 1'b1;
        end
    end

    assign hit_o = en_i && cond_i && (cnt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fsup_cs_short.sv
module fsup_cs_short #(
    parameter int BLANK_LO_CYCLES = 110,
    parameter int BLANK_HI_CYCLES = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_on_i,
    input  logic line_high_i,
    input  logic cs_low_i,
    output logic hit_o
);
    localparam int BMAX = (BLANK_LO_CYCLES > BLANK_HI_CYCLES) ? BLANK_LO_CYCLES : BLANK_HI_CYCLES;
    localparam int W    = $clog2(BMAX + 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] blank_sel;

    always_comb begin
        blank_sel = line_high_i ? W'(BLANK_HI_CYCLES) : W'(BLANK_LO_CYCLES);
        cnt_d     = '0;
        if (drv_on_i) begin
            cnt_d = (cnt_q == W'(BMAX)) ? cnt_q : cnt_q + 1'b1;
        end
    end

    assign hit_o = drv_on_i && cs_low_i && (cnt_q >= blank_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fsup_fsm.sv
module fsup_fsm
    import fsup_pkg::*;
#(
    parameter bit LATCHED    = 1'b0,
    parameter int REC_CYCLES = 40_000_000,
    parameter int SS_CYCLES  = 400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vcc_on_i,
    input  logic        vcc_off_ok_i,
    input  logic        vcc_rst_ok_i,
    input  logic        vcc_ovp_i,
    input  logic        line_ok_i,
    input  logic        tsd_i,
    input  logic        severe_i,
    input  logic        cs_short_i,
    output fsup_state_e state_o,
    output logic        softstart_o
);
    localparam int RW = $clog2(REC_CYCLES + 1);
    localparam int SW = $clog2(SS_CYCLES + 1);

    typedef struct packed {
        fsup_state_e   st;
        logic [RW-1:0] rec;
        logic [SW-1:0] ss;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!vcc_rst_ok_i) begin
            r_d.st = ST_RESET;
        end else begin
            unique case (r_q.st)
                ST_RESET: if (vcc_on_i) r_d.st = ST_STOP;
                ST_STOP: begin
                    if (!vcc_off_ok_i)                            r_d.st = ST_RESET;
                    else if (line_ok_i && !tsd_i && !vcc_ovp_i)   r_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (!vcc_off_ok_i)                            r_d.st = ST_RESET;
                    else if (severe_i)                            r_d.st = LATCHED ? ST_LATCH : ST_TIMER;
                    else if (vcc_ovp_i)                           r_d.st = ST_TIMER;
                    else if (!line_ok_i || tsd_i || cs_short_i)   r_d.st = ST_DISCH;
                end
                ST_DISCH: if (!vcc_off_ok_i || line_ok_i) r_d.st = ST_RESET;
                ST_TIMER: if ((r_q.rec == RW'(REC_CYCLES)) && vcc_on_i) r_d.st = ST_STOP;
                ST_LATCH: r_d.st = ST_LATCH;
                default:  r_d.st = ST_RESET;
            endcase
        end

        if (r_q.st == ST_TIMER)
            r_d.rec = (r_q.rec == RW'(REC_CYCLES)) ? r_q.rec : r_q.rec + 1'b1;
        else
            r_d.rec = '0;

        if (r_d.st == ST_RUN && r_q.st != ST_RUN)
            r_d.ss = SW'(SS_CYCLES);
        else if (r_q.st == ST_RUN && r_q.ss != '0)
            r_d.ss = r_q.ss - 1'b1;
        else if (r_q.st != ST_RUN)
            r_d.ss = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RESET, rec: '0, ss: '0};
        else        r_q <= r_d;
    end

    assign state_o     = r_q.st;
    assign softstart_o = (r_q.st == ST_RUN) && (r_q.ss != '0);
endmodule

// File: rtl/flyback_fault_supervisor.sv
module flyback_fault_supervisor
    import fsup_pkg::*;
#(
    parameter bit LATCHED         = 1'b0,
    parameter int AUX_CYCLES      = 900_000,
    parameter int REC_CYCLES      = 40_000_000,
    parameter int SS_CYCLES       = 400,
    parameter int BLANK_LO_CYCLES = 110,
    parameter int BLANK_HI_CYCLES = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_on_i,
    input  logic       vcc_off_ok_i,
    input  logic       vcc_rst_ok_i,
    input  logic       vcc_ovp_i,
    input  logic       line_ok_i,
    input  logic       tsd_i,
    input  logic       cs_low_i,
    input  logic       wod_i,
    input  logic       leb_i,
    input  logic       drv_on_i,
    input  logic       line_high_i,
    input  logic       zcd_short_i,
    output logic       run_en_o,
    output logic       startup_low_o,
    output logic       softstart_o,
    output logic [2:0] state_o
);
    fsup_state_e st;
    logic aux_hit, cs_hit, wod_hit, in_run;

    assign in_run  = (st == ST_RUN);
    assign wod_hit = wod_i && leb_i;

    fsup_qual_timer #(.LIMIT(AUX_CYCLES)) u_aux (
        .clk(clk), .rst_n(rst_n), .en_i(in_run), .cond_i(zcd_short_i), .hit_o(aux_hit)
    );

    fsup_cs_short #(.BLANK_LO_CYCLES(BLANK_LO_CYCLES), .BLANK_HI_CYCLES(BLANK_HI_CYCLES)) u_cs (
        .clk(clk), .rst_n(rst_n), .drv_on_i(drv_on_i), .line_high_i(line_high_i),
        .cs_low_i(cs_low_i), .hit_o(cs_hit)
    );

    fsup_fsm #(.LATCHED(LATCHED), .REC_CYCLES(REC_CYCLES), .SS_CYCLES(SS_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .vcc_on_i(vcc_on_i), .vcc_off_ok_i(vcc_off_ok_i), .vcc_rst_ok_i(vcc_rst_ok_i),
        .vcc_ovp_i(vcc_ovp_i), .line_ok_i(line_ok_i), .tsd_i(tsd_i),
        .severe_i(aux_hit || wod_hit), .cs_short_i(cs_hit),
        .state_o(st), .softstart_o(softstart_o)
    );

    assign run_en_o      = in_run && !wod_hit;
    assign startup_low_o = (st == ST_RESET);
    assign state_o       = st;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker
    import fsup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_on_i,
    input logic       vcc_off_ok_i,
    input logic       vcc_rst_ok_i,
    input logic       wod_i,
    input logic       leb_i,
    input logic       run_en_o,
    input logic       softstart_o,
    input logic [2:0] state_o
);
    AST_RUN_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_en_o |-> state_o == ST_RUN) else $error("run enable outside Run"); // R11

    AST_RESET_ON_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_rst_ok_i |=> state_o == ST_RESET) else $error("no reset on low supply"); // R10

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LATCH && vcc_rst_ok_i) |=> state_o == ST_LATCH) else $error("latch released"); // R9

    AST_WOD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUN && vcc_rst_ok_i && vcc_off_ok_i && wod_i && leb_i)
        |=> (state_o == ST_TIMER || state_o == ST_LATCH)) else $error("winding short missed"); // R7

    AST_RESET_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RESET && vcc_rst_ok_i && vcc_on_i) |=> state_o == ST_STOP) else $error("no start"); // R2

    AST_SOFTSTART_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUN && $past(state_o) != ST_RUN) |-> softstart_o) else $error("no soft-start"); // R3

    AST_TIMER_EXIT_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_STOP && $past(state_o) == ST_TIMER) |-> $past(vcc_on_i)) else $error("timer exit low supply"); // R5
endmodule

bind flyback_fault_supervisor fsup_checker u_chk (
    .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on_i), .vcc_off_ok_i(vcc_off_ok_i),
    .vcc_rst_ok_i(vcc_rst_ok_i), .wod_i(wod_i), .leb_i(leb_i),
    .run_en_o(run_en_o), .softstart_o(softstart_o), .state_o(state_o)
);

// File: tb/sim_flyback_fault_supervisor.sv
`timescale 1ns/1ps
module sim_flyback_fault_supervisor;
    localparam int AUX = 8, REC = 20, SS = 5, BL = 6, BH = 3;
    localparam int BMAX = (BL > BH) ? BL : BH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_on = 0, vcc_off_ok = 1, vcc_rst_ok = 1, vcc_ovp = 0, line_ok = 1, tsd = 0;
    logic cs_low = 0, wod = 0, leb = 0, drv_on = 0, line_high = 0, zcd_short = 0;
    logic       run_en [2];
    logic       st_low [2];
    logic       ss_o   [2];
    logic [2:0] state  [2];

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_st [2], m_rec [2], m_ss [2], m_aux [2], m_cs [2];

    always #2.5 clk = ~clk;

    flyback_fault_supervisor #(.LATCHED(1'b0), .AUX_CYCLES(AUX), .REC_CYCLES(REC), .SS_CYCLES(SS),
        .BLANK_LO_CYCLES(BL), .BLANK_HI_CYCLES(BH)) u0 (
        .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_off_ok_i(vcc_off_ok), .vcc_rst_ok_i(vcc_rst_ok),
        .vcc_ovp_i(vcc_ovp), .line_ok_i(line_ok), .tsd_i(tsd), .cs_low_i(cs_low), .wod_i(wod),
        .leb_i(leb), .drv_on_i(drv_on), .line_high_i(line_high), .zcd_short_i(zcd_short),
        .run_en_o(run_en[0]), .startup_low_o(st_low[0]), .softstart_o(ss_o[0]), .state_o(state[0]));

    flyback_fault_supervisor #(.LATCHED(1'b1), .AUX_CYCLES(AUX), .REC_CYCLES(REC), .SS_CYCLES(SS),
        .BLANK_LO_CYCLES(BL), .BLANK_HI_CYCLES(BH)) u1 (
        .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_off_ok_i(vcc_off_ok), .vcc_rst_ok_i(vcc_rst_ok),
        .vcc_ovp_i(vcc_ovp), .line_ok_i(line_ok), .tsd_i(tsd), .cs_low_i(cs_low), .wod_i(wod),
        .leb_i(leb), .drv_on_i(drv_on), .line_high_i(line_high), .zcd_short_i(zcd_short),
        .run_en_o(run_en[1]), .startup_low_o(st_low[1]), .softstart_o(ss_o[1]), .state_o(state[1]));

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check(string tag, string what, int v, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s u%0d: actual %0d expected %0d", tag, what, v, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_st[v] = 0; m_rec[v] = 0; m_ss[v] = 0; m_aux[v] = 0; m_cs[v] = 0;
        end
    endtask

    // Next model state from the requirements, for variant v (v=1 is the latched build).
    task automatic model_step(int v);
        int s, ns, blank;
        bit sev, csh;
        s     = m_st[v];
        blank = line_high ? BH : BL;
        sev   = (wod && leb) || (zcd_short && s == 2 && m_aux[v] == AUX - 1);
        csh   = drv_on && cs_low && (m_cs[v] >= blank);
        ns    = s;
        if (!vcc_rst_ok) ns = 0;
        else case (s)
            0: if (vcc_on) ns = 1;
            1: if (!vcc_off_ok) ns = 0; else if (line_ok && !tsd && !vcc_ovp) ns = 2;
            2: if (!vcc_off_ok) ns = 0;
               else if (sev) ns = (v == 1) ? 5 : 4;
               else if (vcc_ovp) ns = 4;
               else if (!line_ok || tsd || csh) ns = 3;
            3: if (!vcc_off_ok || line_ok) ns = 0;
            4: if (m_rec[v] == REC && vcc_on) ns = 1;
            default: ns = s;
        endcase
        if (ns == 2 && s != 2) m_ss[v] = SS;
        else if (s == 2 && m_ss[v] > 0) m_ss[v] = m_ss[v] - 1;
        else if (s != 2) m_ss[v] = 0;
        m_rec[v] = (s == 4) ? min2(m_rec[v] + 1, REC) : 0;
        m_aux[v] = (zcd_short && s == 2) ? min2(m_aux[v] + 1, AUX - 1) : 0;
        m_cs[v]  = drv_on ? min2(m_cs[v] + 1, BMAX) : 0;
        m_st[v]  = ns;
    endtask

    // One cycle: compare outputs against the model (inputs already set), advance, wait.
    task automatic cyc(string tag);
        #1;
        for (int v = 0; v < 2; v++) begin
            check(tag, "state", v, int'(state[v]), m_st[v]);
            check(tag, "run_en", v, int'(run_en[v]), int'(m_st[v] == 2 && !(wod && leb)));
            check(tag, "startup_low", v, int'(st_low[v]), int'(m_st[v] == 0));
            check(tag, "softstart", v, int'(ss_o[v]), int'(m_st[v] == 2 && m_ss[v] != 0));
        end
        if (rst_n) begin
            model_step(0);
            model_step(1);
        end
        @(negedge clk);
    endtask

    task automatic good_inputs();
        vcc_on = 1; vcc_off_ok = 1; vcc_rst_ok = 1; vcc_ovp = 0; line_ok = 1; tsd = 0;
        cs_low = 0; wod = 0; leb = 0; drv_on = 0; line_high = 0; zcd_short = 0;
    endtask

    task automatic go_run(string tag);
        good_inputs();
        vcc_rst_ok = 0; cyc(tag);
        vcc_rst_ok = 1;
        repeat (3) cyc(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        cyc("R1");
        rst_n = 1;
        vcc_on = 0;
        cyc("R1");
        cyc("R1");

        // R2: start and fall back
        line_ok = 0; vcc_on = 1; cyc("R2");
        repeat (2) cyc("R2");
        vcc_off_ok = 0; cyc("R2");
        cyc("R2");

        // R3: soft-start window on entry
        good_inputs();
        repeat (SS + 4) cyc("R3");

        // R4: mild fault and return
        line_ok = 0; cyc("R4");
        repeat (2) cyc("R4");
        line_ok = 1; cyc("R4");
        tsd = 1; repeat (3) cyc("R4");
        tsd = 0;

        // R5: over-voltage, timer, supply gate on exit
        go_run("R5");
        vcc_ovp = 1; cyc("R5");
        vcc_ovp = 0; vcc_on = 0;
        repeat (REC + 6) cyc("R5");
        vcc_on = 1; repeat (3) cyc("R5");

        // R6: interrupted aux short, then a full one
        go_run("R6");
        zcd_short = 1; repeat (AUX - 1) cyc("R6");
        zcd_short = 0; cyc("R6");
        zcd_short = 1; repeat (AUX + 1) cyc("R6");
        zcd_short = 0;

        // R9: latch survives off-level loss, releases on reset-level loss
        vcc_off_ok = 0; vcc_on = 0; repeat (4) cyc("R9");
        vcc_rst_ok = 0; cyc("R9");
        cyc("R9");

        // R7: comparator outside blanking is ignored; inside it faults at once
        go_run("R7");
        wod = 1; leb = 0; repeat (4) cyc("R7");
        leb = 1; cyc("R7");
        wod = 0; leb = 0; repeat (2) cyc("R7");

        // R8: sense short, both line ranges, plus an early release
        go_run("R8");
        drv_on = 1; cs_low = 1; line_high = 1; repeat (BH + 2) cyc("R8");
        go_run("R8");
        drv_on = 1; line_high = 0; cs_low = 1; repeat (BL - 1) cyc("R8");
        drv_on = 0; cyc("R8");
        drv_on = 1; repeat (BL + 2) cyc("R8");
        drv_on = 0; cs_low = 0;

        // R10: coincident faults resolve by priority
        go_run("R10");
        wod = 1; leb = 1; vcc_ovp = 1; tsd = 1; line_ok = 0; cyc("R10");
        good_inputs(); cyc("R10");
        go_run("R10");
        vcc_ovp = 1; tsd = 1; cyc("R10");
        good_inputs(); cyc("R10");
        go_run("R10");
        vcc_off_ok = 0; vcc_ovp = 1; cyc("R10");
        good_inputs(); cyc("R10");

        // R11: random stimulus with held waveforms
        void'($urandom(32'h5EED_1234));
        good_inputs();
        for (int i = 0; i < 30000; i++) begin
            vcc_rst_ok = ($urandom_range(999) >= 2);
            vcc_off_ok = ($urandom_range(99) >= 2);
            vcc_on     = ($urandom_range(99) < 60);
            vcc_ovp    = ($urandom_range(99) < 2);
            tsd        = ($urandom_range(99) < 2);
            leb        = ($urandom_range(99) < 30);
            wod        = ($urandom_range(99) < 4);
            if ($urandom_range(99) < 5)  line_ok   = ~line_ok;
            if ($urandom_range(99) < 15) drv_on    = ~drv_on;
            if ($urandom_range(99) < 20) cs_low    = ~cs_low;
            if ($urandom_range(99) < 2)  line_high = ~line_high;
            if ($urandom_range(99) < 8)  zcd_short = ~zcd_short;
            if (!line_ok && $urandom_range(99) < 10) line_ok = 1;
            cyc("R11");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule